// File: doc/BRIEF.md
# Audio DAC settling status register bank

This block is the register bank of an audio output path. It holds the volume word, two audio control words, a DAC power control word, two clock-synthesis words, a soft-step control word and twenty 16-bit tone-shaping coefficients. Each register is written through a masked port. Two status views tell software when analog settling is complete. The first shows whether a volume ramp has finished. The second shows whether a DAC power-down has completed. Settling is measured in clock cycles since the event that started it, and the length of the wait is the parameter `SETTLE_CYCLES` (at least 2).

Software drives an offset, a write enable with data, and a read strobe. The read data is registered: it takes the value of the addressed register at the clock edge that samples `rdStrobe`, and it holds that value until the next strobe. Reads of control word 3 are destructive for its two event flags.

The offset map is fixed, because the tests depend on it:

| Offset | Register |
| --- | --- |
| 0x00 | control 1 |
| 0x01 | fixed 0xFF00 |
| 0x02 | volume |
| 0x03 | fixed 0x8B00 |
| 0x04 | control 2 |
| 0x05 | power |
| 0x06 | control 3 |
| 0x07–0x1A | coefficients |
| 0x1B | clock word 1 |
| 0x1C | clock word 2 |
| 0x1D | control 4 |

Top module: `audio_status_regs`

## Requirements
- R1: A volume write (offset 0x02) at clock edge E0 restarts the volume timer. A read of control 2 (offset 0x04) sampled at edge E0+k returns bits 3 and 2 as 0 when k < SETTLE_CYCLES and as 1 when k >= SETTLE_CYCLES. This applies while soft-stepping is enabled and power bit 10 is clear.
- R2: When soft-stepping is disabled, or when power bit 10 is set, control 2 bits 3 and 2 read as 1 regardless of the volume timer.
- R3: Power writes (offset 0x05) keep only the bits in mask 0x9543. Power reads return 0x2AA0 ORed with the stored value, with bit 6 also set as described in R4.
- R4: Power bit 10 going from 0 to 1 at edge E0 restarts the power-down timer. A rewrite while bit 10 is already set does not restart it. Power read bit 6 is 1 when the stored bit 6 is 1, or when bit 10 is set and the read is sampled at E0+k with k >= SETTLE_CYCLES.
- R5: Control 3 writes (offset 0x06) change only bits 15:11. A read returns the stored word with bit 0 forced to 1. The read then clears bits 7:6.
- R6: Control 3 bit 7 is set when a volume settling interval completes. Control 3 bit 6 is set when a power-down interval completes while power bit 10 is still set. Both bits stay set until a read of control 3.
- R7: Write masks are 0x0F3F for control 1, 0xF7F2 for control 2, and 0xFFFC for clock words 1 and 2. Control 2 reads return the stored value ORed with the bit 3:2 status.
- R8: Writing control 4 (offset 0x1D) with bit 14 set disables soft-stepping, and writing bit 14 clear enables it. Control 4 reads return bit 14 as the inverse of the enable, and all other bits as 0.
- R9: After reset, the registers hold these values: control 1 0x0000, control 2 0x4410, clock word 1 0x1004, clock word 2 0x0000, volume 0xFFFF, power 0x8540 and control 3 0x0000. Soft-stepping is enabled. Both timers are already settled, and neither event flag is pending.
- R10: Offsets 0x07 to 0x1A are twenty independent 16-bit read/write coefficients, reset to 0.
- R11: Offsets 0x01 and 0x03 read 0xFF00 and 0x8B00 and ignore writes. Offsets 0x1E and 0x1F read 0xFFFF and ignore writes.
- R12: `rdData` changes only at a clock edge that samples `rdStrobe` high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 5 | Register offset |
| wrEn | input | 1 | Write enable for the addressed register |
| wrData | input | 16 | Write data |
| rdStrobe | input | 1 | Read request for the addressed register |
| rdData | output | 16 | Registered read data |

## Verification
The assertions assume that a read and a write are never issued in the same cycle. They also assume that `SETTLE_CYCLES` is at least 2, so that a restarted timer is visibly unsettled for one cycle. The bench drives each operation on its own falling edge, with exactly one operation per cycle, so a write and a read never overlap. It builds the settling windows from counted idle cycles, and it runs with a short settling parameter so that both sides of every window are read back.

// File: rtl/audio_regs_pkg.sv
package audio_regs_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int NUM_COEF  = 20;
  localparam int COEF_BASE = 7;

  localparam logic [ADDR_W-1:0] OFF_CTL1  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_FIXA  = 5'h01;
  localparam logic [ADDR_W-1:0] OFF_VOL   = 5'h02;
  localparam logic [ADDR_W-1:0] OFF_FIXB  = 5'h03;
  localparam logic [ADDR_W-1:0] OFF_CTL2  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_PWR   = 5'h05;
  localparam logic [ADDR_W-1:0] OFF_CTL3  = 5'h06;
  localparam logic [ADDR_W-1:0] OFF_PLL1  = 5'h1B;
  localparam logic [ADDR_W-1:0] OFF_PLL2  = 5'h1C;
  localparam logic [ADDR_W-1:0] OFF_CTL4  = 5'h1D;

  localparam logic [DATA_W-1:0] MASK_CTL1 = 16'h0F3F;
  localparam logic [DATA_W-1:0] MASK_CTL2 = 16'hF7F2;
  localparam logic [DATA_W-1:0] MASK_PWR  = 16'h9543;
  localparam logic [DATA_W-1:0] MASK_PLL  = 16'hFFFC;
  localparam logic [DATA_W-1:0] PWR_ONES  = 16'h2AA0;
  localparam logic [DATA_W-1:0] FIXA_VAL  = 16'hFF00;
  localparam logic [DATA_W-1:0] FIXB_VAL  = 16'h8B00;
  localparam logic [DATA_W-1:0] UNMAPPED  = 16'hFFFF;

  localparam logic [DATA_W-1:0] RST_CTL2  = 16'h4410;
  localparam logic [DATA_W-1:0] RST_PLL1  = 16'h1004;
  localparam logic [DATA_W-1:0] RST_VOL   = 16'hFFFF;
  localparam logic [DATA_W-1:0] RST_PWR   = 16'h8540;

  localparam int PWR_DOWN_BIT = 10;
  localparam int PWR_DONE_BIT = 6;

  typedef struct packed {
    logic wrCtl1;
    logic wrVol;
    logic wrCtl2;
    logic wrPwr;
    logic wrCtl3;
    logic wrCoef;
    logic wrPll1;
    logic wrPll2;
    logic wrCtl4;
    logic rdCtl3;
    logic volSettled;
    logic pwrSettled;
    logic volDone;
    logic pwrDone;
  } ctlStrobes_t;
endpackage

// File: rtl/audio_settle_timer.sv
module audio_settle_timer #(
  parameter int SETTLE_CYCLES = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  output logic settled,
  output logic doneEvt
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SETTLE_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] elapsed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) elapsed <= FULL;
    else if (start) elapsed <= CNT_W'(1);
    else if (elapsed != FULL) elapsed <= elapsed + CNT_W'(1);
  end

  assign settled = (elapsed == FULL);
  assign doneEvt = !start && (elapsed == LAST);

  // R1: a restart always leaves the timer unsettled for at least a cycle
  assert_restart_unsettled_R1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !settled);
  // R4: once settled, the timer stays settled until restarted
  assert_settled_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (settled && !start) |=> settled);
endmodule

// File: rtl/audio_ctrl_decode.sv
module audio_ctrl_decode
  import audio_regs_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  input  logic              pwrDownBit,
  output ctlStrobes_t       strb
);
  localparam int NUM_TIMERS = 2;

  logic [NUM_TIMERS-1:0] tStart, tSettled, tDone;

  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (regAddr)
        OFF_CTL1: strb.wrCtl1 = 1'b1;
        OFF_VOL:  strb.wrVol  = 1'b1;
        OFF_CTL2: strb.wrCtl2 = 1'b1;
        OFF_PWR:  strb.wrPwr  = 1'b1;
        OFF_CTL3: strb.wrCtl3 = 1'b1;
        OFF_PLL1: strb.wrPll1 = 1'b1;
        OFF_PLL2: strb.wrPll2 = 1'b1;
        OFF_CTL4: strb.wrCtl4 = 1'b1;
        default:  strb.wrCoef = (int'(regAddr) >= COEF_BASE) &&
                                (int'(regAddr) < COEF_BASE + NUM_COEF);
      endcase
    end
    strb.rdCtl3     = rdStrobe && (regAddr == OFF_CTL3);
    strb.volSettled = tSettled[0];
    strb.pwrSettled = tSettled[1];
    strb.volDone    = tDone[0];
    strb.pwrDone    = tDone[1];
  end

  assign tStart[0] = wrEn && (regAddr == OFF_VOL);
  assign tStart[1] = wrEn && (regAddr == OFF_PWR) && wrData[PWR_DOWN_BIT] && !pwrDownBit;

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_timer
    audio_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk(clk), .rstN(rstN), .start(tStart[t]),
      .settled(tSettled[t]), .doneEvt(tDone[t])
    );
  end

  // R1: a volume write leaves the volume status unsettled in the next cycle
  assert_vol_restart_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrVol |=> !strb.volSettled);
  // R4: a rewrite with bit 10 already set does not disturb a settled timer
  assert_pwr_no_restart_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrPwr && pwrDownBit && strb.pwrSettled) |=> strb.pwrSettled);
endmodule

// File: rtl/audio_reg_datapath.sv
module audio_reg_datapath
  import audio_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStrobe,
  input  ctlStrobes_t       strb,
  output logic              pwrDownBit,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] ctl1Reg, ctl2Reg, volReg, pwrReg, pll1Reg, pll2Reg;
  logic [4:0]        ctl3High;
  logic [1:0]        ctl3Flags;
  logic              softEn;
  logic [DATA_W-1:0] coefReg [NUM_COEF];
  logic [DATA_W-1:0] rdNext;
  logic              rampBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl1Reg <= '0;
      ctl2Reg <= RST_CTL2;
      volReg  <= RST_VOL;
      pwrReg  <= RST_PWR;
      pll1Reg <= RST_PLL1;
      pll2Reg <= '0;
      softEn  <= 1'b1;
    end else begin
      if (strb.wrCtl1) ctl1Reg <= wrData & MASK_CTL1;
      if (strb.wrCtl2) ctl2Reg <= wrData & MASK_CTL2;
      if (strb.wrVol)  volReg  <= wrData;
      if (strb.wrPwr)  pwrReg  <= wrData & MASK_PWR;
      if (strb.wrPll1) pll1Reg <= wrData & MASK_PLL;
      if (strb.wrPll2) pll2Reg <= wrData & MASK_PLL;
      if (strb.wrCtl4) softEn  <= !wrData[14];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctl3High  <= '0;
      ctl3Flags <= '0;
    end else begin
      if (strb.wrCtl3) ctl3High <= wrData[15:11];
      ctl3Flags <= {(strb.rdCtl3 ? 1'b0 : ctl3Flags[1]) | strb.volDone,
                    (strb.rdCtl3 ? 1'b0 : ctl3Flags[0]) |
                      (strb.pwrDone && pwrReg[PWR_DOWN_BIT])};
    end
  end

  for (genvar i = 0; i < NUM_COEF; i++) begin : g_coef
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) coefReg[i] <= '0;
      else if (strb.wrCoef && (int'(regAddr) == COEF_BASE + i)) coefReg[i] <= wrData;
    end
  end

  assign pwrDownBit = pwrReg[PWR_DOWN_BIT];
  assign rampBusy   = softEn && !pwrReg[PWR_DOWN_BIT] && !strb.volSettled;

  always_comb begin
    rdNext = UNMAPPED;
    unique case (regAddr)
      OFF_CTL1: rdNext = ctl1Reg;
      OFF_FIXA: rdNext = FIXA_VAL;
      OFF_VOL:  rdNext = volReg;
      OFF_FIXB: rdNext = FIXB_VAL;
      OFF_CTL2: rdNext = ctl2Reg | {12'b0, !rampBusy, !rampBusy, 2'b00};
      OFF_PWR: begin
        rdNext = PWR_ONES | pwrReg;
        rdNext[PWR_DONE_BIT] = pwrReg[PWR_DONE_BIT] |
                               (pwrReg[PWR_DOWN_BIT] && strb.pwrSettled);
      end
      OFF_CTL3: rdNext = {ctl3High, 3'b000, ctl3Flags, 5'b00000, 1'b1};
      OFF_PLL1: rdNext = pll1Reg;
      OFF_PLL2: rdNext = pll2Reg;
      OFF_CTL4: rdNext = {1'b0, !softEn, 14'b0};
      default: begin
        for (int i = 0; i < NUM_COEF; i++)
          if (int'(regAddr) == COEF_BASE + i) rdNext = coefReg[i];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (rdStrobe) rdData <= rdNext;
  end

  // R5: control 3 reads always show bit 0 set
  assert_ctl3_bit0_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdCtl3 |=> rdData[0]);
  // R5: a read with no new event leaves both flags clear
  assert_ctl3_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdCtl3 && !strb.volDone && !strb.pwrDone) |=> (ctl3Flags == 2'b00));
  // R3: power reads always carry the fixed ones
  assert_pwr_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && regAddr == OFF_PWR) |=> ((rdData & PWR_ONES) == PWR_ONES));
  // R12: read data holds without a strobe
  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(rdData));
endmodule

// File: rtl/audio_status_regs.sv
module audio_status_regs
  import audio_regs_pkg::*;
#(
  parameter int SETTLE_CYCLES = 50
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                wrEn,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                rdStrobe,
  output logic [DATA_W-1:0]   rdData
);
  ctlStrobes_t strb;
  logic        pwrDownBit;

  audio_ctrl_decode #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdStrobe(rdStrobe), .pwrDownBit(pwrDownBit), .strb(strb)
  );

  audio_reg_datapath u_dp (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData),
    .rdStrobe(rdStrobe), .strb(strb), .pwrDownBit(pwrDownBit), .rdData(rdData)
  );
endmodule

// File: tb/sim_audio_status_regs.sv
module sim_audio_status_regs;
  localparam int D = 6;
  localparam int NV = 31;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdStrobe = 1'b0;
  logic [15:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  audio_status_regs #(.SETTLE_CYCLES(D)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn),
    .wrData(wrData), .rdStrobe(rdStrobe), .rdData(rdData)
  );

  // {write, offset, data, expected read, requirement number}
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 5'h00, 16'h0000, 16'h0000, 4'd9},  // R9
    {1'b0, 5'h04, 16'h0000, 16'h441C, 4'd9},  // R9 with R2 status ones
    {1'b0, 5'h1B, 16'h0000, 16'h1004, 4'd9},  // R9
    {1'b0, 5'h1C, 16'h0000, 16'h0000, 4'd9},  // R9
    {1'b0, 5'h02, 16'h0000, 16'hFFFF, 4'd9},  // R9
    {1'b0, 5'h05, 16'h0000, 16'hAFE0, 4'd9},  // R9 with R3
    {1'b0, 5'h1D, 16'h0000, 16'h0000, 4'd9},  // R9 soft-step enabled
    {1'b0, 5'h06, 16'h0000, 16'h0001, 4'd9},  // R9 with R5
    {1'b1, 5'h00, 16'hFFFF, 16'h0000, 4'd7},
    {1'b0, 5'h00, 16'h0000, 16'h0F3F, 4'd7},  // R7
    {1'b1, 5'h04, 16'hFFFF, 16'h0000, 4'd7},
    {1'b0, 5'h04, 16'h0000, 16'hF7FE, 4'd7},  // R7
    {1'b1, 5'h1B, 16'hFFFF, 16'h0000, 4'd7},
    {1'b0, 5'h1B, 16'h0000, 16'hFFFC, 4'd7},  // R7
    {1'b1, 5'h1C, 16'h1235, 16'h0000, 4'd7},
    {1'b0, 5'h1C, 16'h0000, 16'h1234, 4'd7},  // R7
    {1'b1, 5'h01, 16'h1234, 16'h0000, 4'd11},
    {1'b0, 5'h01, 16'h0000, 16'hFF00, 4'd11}, // R11
    {1'b1, 5'h03, 16'h0000, 16'h0000, 4'd11},
    {1'b0, 5'h03, 16'h0000, 16'h8B00, 4'd11}, // R11
    {1'b0, 5'h1E, 16'h0000, 16'hFFFF, 4'd11}, // R11
    {1'b1, 5'h1F, 16'h0000, 16'h0000, 4'd11},
    {1'b0, 5'h1F, 16'h0000, 16'hFFFF, 4'd11}, // R11
    {1'b1, 5'h07, 16'hABCD, 16'h0000, 4'd10},
    {1'b1, 5'h1A, 16'h5A5A, 16'h0000, 4'd10},
    {1'b0, 5'h07, 16'h0000, 16'hABCD, 4'd10}, // R10
    {1'b0, 5'h1A, 16'h0000, 16'h5A5A, 4'd10}, // R10
    {1'b0, 5'h08, 16'h0000, 16'h0000, 4'd10}, // R10
    {1'b1, 5'h06, 16'hFFFF, 16'h0000, 4'd5},
    {1'b0, 5'h06, 16'h0000, 16'hF801, 4'd5},  // R5
    {1'b0, 5'h02, 16'h0000, 16'hFFFF, 4'd9}   // R9 volume unchanged
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1; rdStrobe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    regAddr = a; wrEn = 1'b0; rdStrobe = 1'b1;
    @(posedge clk);
    #1 check(req, rdData, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrEn = 1'b0; rdStrobe = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][41]) wr(VEC[v][40:36], VEC[v][35:20]);
      else rd(VEC[v][40:36], VEC[v][19:4], $sformatf("R%0d", VEC[v][3:0]));
    end

    // R3: cleared power word reads only the fixed ones
    wr(5'h05, 16'h0000);
    rd(5'h05, 16'h2AA0, "R3");

    // R1: settling window after a volume write
    wr(5'h02, 16'h1234);
    for (int k = 1; k <= D + 1; k++)
      rd(5'h04, (k < D) ? 16'hF7F2 : 16'hF7FE, "R1");

    // R6 then R5: the event flag appears and then clears on read
    rd(5'h06, 16'hF881, "R6");
    rd(5'h06, 16'hF801, "R5");

    // R5: a write to control 3 keeps bits 7:6
    wr(5'h02, 16'h0000);
    idle(D + 1);
    wr(5'h06, 16'h0000);
    rd(5'h06, 16'h0081, "R5");
    rd(5'h06, 16'h0001, "R5");

    // R8 and R2: soft-stepping disabled gives settled status at once
    wr(5'h1D, 16'h4000);
    rd(5'h1D, 16'h4000, "R8");
    wr(5'h02, 16'h0005);
    rd(5'h04, 16'hF7FE, "R2");
    wr(5'h1D, 16'h0000);
    rd(5'h1D, 16'h0000, "R8");
    idle(D);
    rd(5'h06, 16'h0081, "R6");

    // R4 and R2: power-down timing
    wr(5'h05, 16'h0400);
    rd(5'h05, 16'h2EA0, "R4");
    rd(5'h04, 16'hF7FE, "R2");
    idle(D);
    rd(5'h05, 16'h2EE0, "R4");
    rd(5'h06, 16'h0041, "R6");
    wr(5'h05, 16'h0400);
    rd(5'h05, 16'h2EE0, "R4");
    wr(5'h05, 16'h0000);
    wr(5'h05, 16'h0400);
    rd(5'h05, 16'h2EA0, "R4");

    // R12: the value holds with no strobe
    idle(3);
    check("R12", rdData, 16'h2EA0);

    // R9: reset in the middle of a run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    rd(5'h05, 16'hAFE0, "R9");
    rd(5'h1B, 16'h1004, "R9");
    rd(5'h07, 16'h0000, "R9");
    idle(2);
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule